// File: doc/BRIEF.md
# I/O Port Bus Cycle Sequencer

This block is a bus master for isolated I/O transfers of one byte on a multiplexed address/data bus. A client presents a request that holds a direction, a 16-bit port number and a write byte. The block then runs a fixed four-state cycle, T1 through T4. In T1 it puts the port number on the bus and pulses the address latch strobe. In T2 and T3 it either releases the low byte lanes and strobes a read, or drives the write byte and strobes a write. In T4 it releases every strobe and the whole bus. Separate strobes mark the cycle as I/O and set the direction and enable of the external data transceivers.

A request is taken only while the sequencer is idle. A `done` pulse marks T4. For a read, `rdata` carries the byte that was on the low lanes at the end of T3. A short-form request sets `req_direct`, which limits the port to the first 256 addresses by clearing the upper address byte. The tri-state bus is split into a value (`bus_ad_o`), lane enables (`bus_ad_oe`) and the returning low byte (`bus_ad_i`).

Top module: `iocyc_seq`

## Requirements
- R1: After synchronous reset, and in every idle state, `bus_ale`=0, `bus_iom`=0, `bus_dtr`=1, `bus_den_n`=1, `bus_rd_n`=1, `bus_wr_n`=1, `bus_ad_oe`=2'b00, `done`=0 and `req_ready`=1. Directly after reset `rdata`=0.
- R2: The cycle after a request is accepted is T1. In T1, `bus_ale`=1, `bus_ad_oe`=2'b11 (bit 0 enables lanes 7:0, bit 1 enables lanes 15:8), `bus_ad_o` equals the port address, `bus_iom`=1, and `bus_den_n`, `bus_rd_n` and `bus_wr_n` are all 1. `bus_ale` is high for exactly one cycle.
- R3: From T1 through T3, `bus_dtr` is 0 for a read (`req_write`=0) and 1 for a write (`req_write`=1).
- R4: In T2 and T3 of a read, `bus_ad_oe`=2'b10 and the upper lanes hold the address upper byte. Also `bus_rd_n`=0, `bus_den_n`=0 and `bus_wr_n`=1.
- R5: In T2 and T3 of a write, `bus_ad_oe`=2'b11, the lanes 7:0 carry the write byte and the lanes 15:8 the address upper byte. Also `bus_wr_n`=0, `bus_den_n`=0 and `bus_rd_n`=1.
- R6: A read captures `bus_ad_i` at the clock edge that ends T3. The value on `bus_ad_i` during T2 has no effect on the result. A write cycle leaves `rdata` unchanged.
- R7: T4 is the fourth cycle after T1 begins. In T4, `done`=1, `rdata` holds the result, both strobes are 1, `bus_ad_oe`=2'b00, `bus_iom`=0, `bus_den_n`=1 and `bus_dtr`=1. `done` is 1 in no other cycle.
- R8: `req_ready` is 1 only when idle. `req_valid` during T1 to T4 is ignored: no new T1 follows T4, and at least one idle cycle separates two cycles.
- R9: When `req_direct`=1, the address driven in T1 and on the upper lanes is {8'h00, req_addr[7:0]}. When `req_direct`=0, it is the full `req_addr`, from 16'h0000 to 16'hFFFF.
- R10: `bus_iom` is 1 exactly in T1, T2 and T3, and `bus_den_n` is 0 only while `bus_iom` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write to port, 0 = read from port |
| req_direct | input | 1 | 1 = short form, port limited to 00H..FFH |
| req_addr | input | 16 | Port address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Idle, request will be taken |
| bus_ale | output | 1 | Address latch strobe, T1 only |
| bus_iom | output | 1 | 1 = I/O cycle, 0 = memory level |
| bus_dtr | output | 1 | Transceiver direction, 1 = transmit, 0 = receive |
| bus_den_n | output | 1 | Transceiver enable, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ad_o | output | 16 | Value driven on the address/data lanes |
| bus_ad_oe | output | 2 | Lane enables: bit 0 lanes 7:0, bit 1 lanes 15:8 |
| bus_ad_i | input | 8 | Low lanes as seen from the bus |
| done | output | 1 | End-of-cycle pulse (T4) |
| rdata | output | 8 | Byte captured by the last read |

## Verification
The bench records the whole control word, the lane enables and the driven value in every state of every cycle, and compares them with the sequence that R1 to R10 give for each direction. It therefore catches a strobe that falls a state early or late, and a direction line that flips after T1. During T2 of each read it drives a decoy byte and only sets the true byte in T3. A sequencer that sampled early would return the decoy. It also checks that a write leaves the last read result in place. It keeps `req_valid` high through a whole cycle, which catches a design that starts a new cycle straight from T4 or takes requests while busy. It checks that short-form requests clear the upper address byte, and that a reset in the middle of a cycle returns every line to its idle level at once.

// File: rtl/iocyc_pkg.sv
package iocyc_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned PAGE_W = 8;
    localparam int unsigned HI_W   = ADDR_W - DATA_W;
    localparam int unsigned LANES  = 2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_T4   = 3'd4
    } state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic ale;
        logic iom;
        logic dtr;
        logic den_n;
        logic rd_n;
        logic wr_n;
    } ctl_t;

    localparam ctl_t CTL_REST = '{ale: 1'b0, iom: 1'b0, dtr: 1'b1,
                                  den_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};

    function automatic logic [ADDR_W-1:0] port_addr(input logic direct,
                                                    input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] r;
        r = a;
        if (direct) r[ADDR_W-1:PAGE_W] = '0;
        return r;
    endfunction

    function automatic state_e step(input state_e s, input logic take);
        state_e n;
        case (s)
            ST_IDLE: n = take ? ST_T1 : ST_IDLE;
            ST_T1:   n = ST_T2;
            ST_T2:   n = ST_T3;
            ST_T3:   n = ST_T4;
            default: n = ST_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/iocyc_fsm.sv
module iocyc_fsm
    import iocyc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  req_t   req_in,
    output state_e state,
    output req_t   req_q,
    output logic   req_ready
);

    state_e nxt;

    assign req_ready = (state == ST_IDLE);
    assign nxt       = step(state, req_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req_q <= '0;
        end else begin
            state <= nxt;
            if (req_ready && req_valid) req_q <= req_in;
        end
    end

endmodule

// File: rtl/iocyc_drive.sv
module iocyc_drive
    import iocyc_pkg::*;
(
    input  state_e            state,
    input  req_t              req_q,
    output ctl_t              ctl,
    output logic [ADDR_W-1:0] ad_o,
    output logic [LANES-1:0]  ad_oe,
    output logic              done
);

    logic [HI_W-1:0] addr_hi;
    assign addr_hi = req_q.addr[ADDR_W-1:DATA_W];

    always_comb begin
        ctl   = CTL_REST;
        ad_o  = '0;
        ad_oe = '0;
        done  = 1'b0;
        case (state)
            ST_T1: begin
                ctl.ale = 1'b1;
                ctl.iom = 1'b1;
                ctl.dtr = req_q.wr;
                ad_o    = req_q.addr;
                ad_oe   = '1;
            end
            ST_T2, ST_T3: begin
                ctl.iom   = 1'b1;
                ctl.dtr   = req_q.wr;
                ctl.den_n = 1'b0;
                ctl.rd_n  = req_q.wr;
                ctl.wr_n  = ~req_q.wr;
                ad_o      = {addr_hi, (req_q.wr ? req_q.wdata : {DATA_W{1'b0}})};
                ad_oe     = {1'b1, req_q.wr};
            end
            ST_T4: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/iocyc_capture.sv
module iocyc_capture
    import iocyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  state_e            state,
    input  logic              is_write,
    input  logic [DATA_W-1:0] bus_ad_i,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst)                                rdata <= '0;
        else if (state == ST_T3 && !is_write)   rdata <= bus_ad_i;
    end

endmodule

// File: rtl/iocyc_seq.sv
module iocyc_seq
    import iocyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_direct,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              bus_ale,
    output logic              bus_iom,
    output logic              bus_dtr,
    output logic              bus_den_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [ADDR_W-1:0] bus_ad_o,
    output logic [LANES-1:0]  bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_i,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    req_t   req_in;
    req_t   req_q;
    state_e state;
    ctl_t   ctl;

    assign req_in = '{wr: req_write, addr: port_addr(req_direct, req_addr),
                      wdata: req_wdata};

    iocyc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .state     (state),
        .req_q     (req_q),
        .req_ready (req_ready)
    );

    iocyc_drive u_drive (
        .state (state),
        .req_q (req_q),
        .ctl   (ctl),
        .ad_o  (bus_ad_o),
        .ad_oe (bus_ad_oe),
        .done  (done)
    );

    iocyc_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .is_write (req_q.wr),
        .bus_ad_i (bus_ad_i),
        .rdata    (rdata)
    );

    assign bus_ale   = ctl.ale;
    assign bus_iom   = ctl.iom;
    assign bus_dtr   = ctl.dtr;
    assign bus_den_n = ctl.den_n;
    assign bus_rd_n  = ctl.rd_n;
    assign bus_wr_n  = ctl.wr_n;

endmodule

// File: rtl/iocyc_chk.sv
module iocyc_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       bus_ale,
    input logic       bus_iom,
    input logic       bus_dtr,
    input logic       bus_den_n,
    input logic       bus_rd_n,
    input logic       bus_wr_n,
    input logic [1:0] bus_ad_oe,
    input logic       done
);

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> !bus_ale); // R2

    AST_ALE_LANES: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> (bus_ad_oe == 2'b11 && bus_iom && bus_den_n)); // R2

    AST_DTR_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_iom && !bus_ale) |-> $stable(bus_dtr)); // R3

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_n)); // R4

    AST_T4_RELEASE: assert property (@(posedge clk) disable iff (rst)
        done |-> (bus_rd_n && bus_wr_n && bus_ad_oe == 2'b00 && !bus_iom
                  && bus_den_n && bus_dtr)); // R7

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(!bus_rd_n || !bus_wr_n) && !req_ready)); // R7

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> !bus_ale); // R8

    AST_DEN_IN_IO: assert property (@(posedge clk) disable iff (rst)
        !bus_den_n |-> bus_iom); // R10

endmodule

bind iocyc_seq iocyc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_ale   (bus_ale),
    .bus_iom   (bus_iom),
    .bus_dtr   (bus_dtr),
    .bus_den_n (bus_den_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_ad_oe (bus_ad_oe),
    .done      (done)
);

// File: tb/iocyc_seq_bench.sv
`timescale 1ns/1ps
module iocyc_seq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_direct;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready, bus_ale, bus_iom, bus_dtr, bus_den_n, bus_rd_n, bus_wr_n;
    logic [15:0] bus_ad_o;
    logic [1:0]  bus_ad_oe;
    logic [7:0]  bus_ad_i;
    logic        done;
    logic [7:0]  rdata;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;
    logic [7:0] last_read;

    always #10 clk = ~clk;

    iocyc_seq u_iocyc_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_direct(req_direct), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .bus_ale(bus_ale), .bus_iom(bus_iom),
        .bus_dtr(bus_dtr), .bus_den_n(bus_den_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
        .bus_ad_i(bus_ad_i), .done(done), .rdata(rdata)
    );

    // {write, direct, addr[15:0], wdata[7:0], decoy[7:0], true_byte[7:0]}
    localparam logic [41:0] VEC [6] = '{
        {1'b0, 1'b0, 16'hA000, 8'h00, 8'h3C, 8'hC3},
        {1'b1, 1'b0, 16'hB000, 8'hFF, 8'h00, 8'h00},
        {1'b0, 1'b1, 16'h12FE, 8'h00, 8'h81, 8'h7E},
        {1'b1, 1'b1, 16'h77AB, 8'h5A, 8'h00, 8'h00},
        {1'b0, 1'b0, 16'hFFFF, 8'h00, 8'hFF, 8'h00},
        {1'b1, 1'b0, 16'h0000, 8'hA5, 8'h00, 8'h00}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {ale, iom, dtr, den_n, rd_n, wr_n} per state: 0 idle, 1..4 = T1..T4
    function automatic logic [5:0] exp_ctl(input int st, input bit wr);
        case (st)
            1:       return {1'b1, 1'b1, wr, 1'b1, 1'b1, 1'b1};
            2, 3:    return {1'b0, 1'b1, wr, 1'b0, wr, ~wr};
            default: return 6'b001111;
        endcase
    endfunction

    function automatic logic [1:0] exp_oe(input int st, input bit wr);
        case (st)
            1:       return 2'b11;
            2, 3:    return {1'b1, wr};
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [5:0] cur_ctl();
        return {bus_ale, bus_iom, bus_dtr, bus_den_n, bus_rd_n, bus_wr_n};
    endfunction

    task automatic check_idle(input string tag);
        chk(cur_ctl() == 6'b001111, {tag, " R1 idle ctl"}, 32'(cur_ctl()), 32'h0F);
        chk(bus_ad_oe == 2'b00 && !done && req_ready, {tag, " R1 idle oe/done/ready"},
            {bus_ad_oe, done, req_ready}, 32'h1);
    endtask

    task automatic run_vec(input logic [41:0] v);
        bit          wr     = v[41];
        bit          direct = v[40];
        logic [15:0] a      = v[39:24];
        logic [7:0]  wd     = v[23:16];
        logic [7:0]  decoy  = v[15:8];
        logic [7:0]  tru    = v[7:0];
        logic [15:0] ea     = direct ? {8'h00, a[7:0]} : a;
        logic [7:0]  er;
        @(negedge clk);
        chk(req_ready, "R8 ready before request", 32'(req_ready), 1);
        req_valid = 1; req_write = wr; req_direct = direct; req_addr = a; req_wdata = wd;
        bus_ad_i  = 8'hEE;
        for (int st = 1; st <= 4; st++) begin
            @(negedge clk);
            if (st == 1) req_valid = 0;
            chk(cur_ctl() == exp_ctl(st, wr), $sformatf("R2/R3/R4/R5/R7 ctl state %0d", st),
                32'(cur_ctl()), 32'(exp_ctl(st, wr)));
            chk(bus_ad_oe == exp_oe(st, wr), $sformatf("R4/R5 lane enables state %0d", st),
                32'(bus_ad_oe), 32'(exp_oe(st, wr)));
            chk(done == (st == 4), $sformatf("R7 done in state %0d", st), 32'(done), 32'(st == 4));
            chk(!req_ready, "R8 busy", 32'(req_ready), 0);
            if (st == 1)
                chk(bus_ad_o == ea, "R2/R9 address in T1", 32'(bus_ad_o), 32'(ea));
            if (st == 2 || st == 3) begin
                chk(bus_ad_o[15:8] == ea[15:8], "R9 upper lanes", 32'(bus_ad_o[15:8]),
                    32'(ea[15:8]));
                if (wr) chk(bus_ad_o[7:0] == wd, "R5 write byte", 32'(bus_ad_o[7:0]), 32'(wd));
            end
            if (st == 2) bus_ad_i = decoy;
            if (st == 3) bus_ad_i = tru;
            if (st == 4) begin
                er = wr ? last_read : tru;
                chk(rdata == er, "R6 read result", 32'(rdata), 32'(er));
                last_read = er;
            end
        end
        @(negedge clk);
        check_idle("R7 after T4");
    endtask

    initial begin
        rst = 1; req_valid = 0; req_write = 0; req_direct = 0;
        req_addr = '0; req_wdata = '0; bus_ad_i = '0; last_read = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_idle("reset");
        chk(rdata == 8'h00, "R1 rdata after reset", 32'(rdata), 0);

        foreach (VEC[i]) run_vec(VEC[i]);

        // R8: request held high through a whole cycle
        @(negedge clk);
        req_valid = 1; req_write = 1; req_direct = 0; req_addr = 16'h1234; req_wdata = 8'h11;
        @(negedge clk);
        chk(bus_ale == 1, "R8 held request starts T1", 32'(bus_ale), 1);
        req_addr = 16'h4321;
        for (int st = 2; st <= 4; st++) begin
            @(negedge clk);
            chk(!bus_ale && !req_ready, $sformatf("R8 no restart in state %0d", st),
                {bus_ale, req_ready}, 0);
        end
        @(negedge clk);
        check_idle("R8 idle gap after T4");
        req_valid = 0;
        @(negedge clk);
        chk(!bus_ale && req_ready, "R8 dropped request stays idle", {bus_ale, req_ready}, 1);
        chk(rdata == last_read, "R6 write keeps rdata", 32'(rdata), 32'(last_read));

        // R1: reset in the middle of a read cycle
        req_valid = 1; req_write = 0; req_addr = 16'h00F0; bus_ad_i = 8'h99;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        chk(!bus_rd_n, "R4 read strobe before reset", 32'(bus_rd_n), 0);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check_idle("R1 mid-cycle reset");
        chk(rdata == 8'h00, "R1 rdata cleared by reset", 32'(rdata), 0);
        @(negedge clk);
        check_idle("R1 stays idle");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule